// File: doc/BRIEF.md
# Snooping MSI Write-Back Cache Controller

This block is a direct-mapped, write-back cache controller for one processor in a small shared-memory system. Each line keeps a tag, a one-word data field and a three-valued coherence state: Invalid, Shared (clean, read-only) or Modified (sole copy, writable, dirty). Processor reads and writes that hit complete in the cycle they are presented. Misses and upgrades wait for the bus grant. On the grant cycle the controller places a read miss, a write miss or a write-back on a shared atomic bus.

At the same time the controller watches transactions that other caches put on the bus. When another cache misses on a line held here, the line is downgraded or invalidated. If the line is dirty, its data is offered on a flush output so that memory can drop its own reply. A processor miss that lands on a dirty line with a different tag writes the old block back first and then issues the new miss. A snoop always wins the cycle: no processor request completes and no bus transaction starts while one is present. Writes complete only on a granted bus cycle or on a Modified hit, so the bus order serializes them.

Top module: `msi_snoop_cache`

## Requirements
- R1: After reset every line is Invalid: no request to the bus, no processor completion and no flush, and the first access to any address misses.
- R2: A processor read to a line that is not held issues a read miss (bus command 1) carrying the full address on the grant cycle. It returns the bus data in that same cycle and installs the line as Shared.
- R3: A processor write to an Invalid line, or to a Shared line with the same tag, issues a write miss (bus command 2) on the grant cycle and leaves the line Modified with the written word.
- R4: A read hit to a Shared or Modified line and a write hit to a Modified line complete in the cycle they are presented. They raise no bus request and return the held word.
- R5: A snooped write miss (command 2) whose address matches a held line invalidates it. If the line was Modified, the flush output is raised with the line's data in that cycle. A snoop whose tag does not match changes nothing.
- R6: A snooped read miss (command 1) that matches a Modified line raises the flush output with its data and leaves the line Shared: it remains readable without a bus transaction, and a later write needs a new write miss.
- R7: A processor miss on a Modified line that holds another tag first issues a write-back (command 3) of the old address {old tag, index} with the old data, without completing. On the next grant it issues the new miss.
- R8: While a miss waits for the grant, the processor request stays stalled and the bus request stays raised.
- R9: In any cycle with a snoop present, no processor request completes and no bus transaction starts. The request is served on the first cycle without a snoop.
- R10: The bus valid output is raised only in a cycle with the grant. The address layout is tag above index, with the index in the low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_i | input | 1 | Processor request, held until completion |
| cpu_we_i | input | 1 | 1 for a write, 0 for a read |
| cpu_addr_i | input | ADDR_W | Word address |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_ready_o | output | 1 | Request completes this cycle |
| cpu_rdata_o | output | DATA_W | Read data, valid with ready on a read |
| bus_req_o | output | 1 | Bus needed for a miss or write-back |
| bus_gnt_i | input | 1 | Arbiter grant for this cycle |
| bus_valid_o | output | 1 | Transaction placed on the bus this cycle |
| bus_cmd_o | output | 2 | 1 read miss, 2 write miss, 3 write-back |
| bus_addr_o | output | ADDR_W | Transaction address |
| bus_data_o | output | DATA_W | Write-back data (write data on a write miss) |
| bus_rdata_i | input | DATA_W | Data returned for a read miss in the grant cycle |
| snp_valid_i | input | 1 | Another cache's transaction is present |
| snp_cmd_i | input | 2 | Snooped command, same encoding as bus_cmd_o |
| snp_addr_i | input | ADDR_W | Snooped address |
| snp_flush_o | output | 1 | Dirty data supplied; memory reply must be dropped |
| snp_data_o | output | DATA_W | Supplied dirty data |

## Verification
The bench targets the transitions where a wrong state encoding stays hidden until a later access. If a snooped read miss left a line Modified, the following write would finish silently instead of issuing a write miss. If a snooped write miss left a Shared line valid, the next read would hit on stale data. The bench also checks conflict replacement of a dirty line. A controller that skipped the write-back would lose the dirty word in memory, and one that completed early would return data before the miss. Finally, a cycle with a snoop and a processor hit at once must not let the hit through, and a delayed grant must produce exactly as many stall cycles as the grant was withheld.

// File: rtl/msi_pkg.sv
`timescale 1ns/1ps
package msi_pkg;

  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_MOD = 2'd2
  } line_state_e;

  typedef enum logic [1:0] {
    BC_NONE   = 2'd0,
    BC_RDMISS = 2'd1,
    BC_WRMISS = 2'd2,
    BC_WBACK  = 2'd3
  } bus_cmd_e;

  // State a held line takes when another cache's transaction matches it.
  function automatic line_state_e snoop_next(line_state_e st, bus_cmd_e cmd);
    if (cmd == BC_WRMISS) return LN_INV;
    if (cmd == BC_RDMISS && st == LN_MOD) return LN_SHR;
    return st;
  endfunction

  // A dirty line must supply its data for any snooped miss.
  function automatic logic snoop_flush(line_state_e st, bus_cmd_e cmd);
    return (st == LN_MOD) && (cmd == BC_RDMISS || cmd == BC_WRMISS);
  endfunction

  function automatic line_state_e fill_state(logic is_write);
    return is_write ? LN_MOD : LN_SHR;
  endfunction

  function automatic bus_cmd_e miss_cmd(logic is_write);
    return is_write ? BC_WRMISS : BC_RDMISS;
  endfunction

endpackage

// File: rtl/msi_line_store.sv
`timescale 1ns/1ps
module msi_line_store
  import msi_pkg::*;
#(
  parameter int NLINES = 4,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  line_state_e       wr_state,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  a_idx,
  output line_state_e       a_state,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output line_state_e       b_state,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data
);

  line_state_e       st_q  [NLINES];
  logic [TAG_W-1:0]  tag_q [NLINES];
  logic [DATA_W-1:0] dat_q [NLINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINES; i++) begin
        st_q[i]  <= LN_INV;
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else if (wr_en) begin
      st_q[wr_idx]  <= wr_state;
      tag_q[wr_idx] <= wr_tag;
      dat_q[wr_idx] <= wr_data;
    end
  end

  // Processor-side and snoop-side lookups see the same lines independently.
  assign a_state = st_q[a_idx];
  assign a_tag   = tag_q[a_idx];
  assign a_data  = dat_q[a_idx];
  assign b_state = st_q[b_idx];
  assign b_tag   = tag_q[b_idx];
  assign b_data  = dat_q[b_idx];

endmodule

// File: rtl/msi_cpu_side.sv
`timescale 1ns/1ps
module msi_cpu_side
  import msi_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              req,
  input  logic              we,
  input  logic [TAG_W-1:0]  tag,
  input  logic [DATA_W-1:0] wdata,
  input  logic              snoop_busy,
  input  logic              gnt,
  input  line_state_e       l_state,
  input  logic [TAG_W-1:0]  l_tag,
  input  logic [DATA_W-1:0] l_data,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              bus_req,
  output logic              issue,
  output bus_cmd_e          cmd,
  output logic [TAG_W-1:0]  bus_tag,
  output logic [DATA_W-1:0] bus_data,
  output logic              wr_en,
  output line_state_e       wr_state,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [DATA_W-1:0] wr_data,
  output logic              hit,
  output logic              wb_issue
);

  logic go, tag_hit, rd_hit, wr_hit, victim_dirty, fill;

  always_comb begin
    go           = req && !snoop_busy;
    tag_hit      = (l_state != LN_INV) && (l_tag == tag);
    rd_hit       = go && !we && tag_hit;
    wr_hit       = go && we && tag_hit && (l_state == LN_MOD);
    hit          = rd_hit || wr_hit;
    victim_dirty = (l_state == LN_MOD) && (l_tag != tag);
    bus_req      = go && !hit;
    issue        = bus_req && gnt;
    wb_issue     = issue && victim_dirty;
    fill         = issue && !victim_dirty;

    cmd      = victim_dirty ? BC_WBACK : miss_cmd(we);
    bus_tag  = victim_dirty ? l_tag : tag;
    bus_data = victim_dirty ? l_data : wdata;

    ready = hit || fill;
    rdata = rd_hit ? l_data : bus_rdata;

    wr_en    = wr_hit || issue;
    wr_state = wb_issue ? LN_INV : fill_state(we);
    wr_tag   = wb_issue ? l_tag : tag;
    wr_data  = wb_issue ? l_data : (we ? wdata : bus_rdata);
  end

endmodule

// File: rtl/msi_snoop_side.sv
`timescale 1ns/1ps
module msi_snoop_side
  import msi_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              valid,
  input  bus_cmd_e          cmd,
  input  logic [TAG_W-1:0]  tag,
  input  line_state_e       l_state,
  input  logic [TAG_W-1:0]  l_tag,
  input  logic [DATA_W-1:0] l_data,
  output logic              hit,
  output logic              flush,
  output logic [DATA_W-1:0] data,
  output logic              wr_en,
  output line_state_e       wr_state
);

  always_comb begin
    hit      = valid && (l_state != LN_INV) && (l_tag == tag);
    flush    = hit && snoop_flush(l_state, cmd);
    data     = flush ? l_data : '0;
    wr_state = snoop_next(l_state, cmd);
    wr_en    = hit && (wr_state != l_state);
  end

endmodule

// File: rtl/msi_snoop_cache.sv
`timescale 1ns/1ps
module msi_snoop_cache
  import msi_pkg::*;
#(
  parameter int NLINES = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic              bus_valid_o,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_flush_o,
  output logic [DATA_W-1:0] snp_data_o
);

  localparam int IDX_W = $clog2(NLINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0] cpu_idx, snp_idx;
  logic [TAG_W-1:0] cpu_tag, snp_tag;
  assign cpu_idx = cpu_addr_i[IDX_W-1:0];
  assign cpu_tag = cpu_addr_i[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr_i[IDX_W-1:0];
  assign snp_tag = snp_addr_i[ADDR_W-1:IDX_W];

  line_state_e       a_state, b_state;
  logic [TAG_W-1:0]  a_tag, b_tag;
  logic [DATA_W-1:0] a_data, b_data;

  // Processor-side results.
  logic              c_issue, c_wr_en, ev_hit, ev_wb_issue;
  bus_cmd_e          c_cmd;
  logic [TAG_W-1:0]  c_bus_tag, c_wr_tag;
  logic [DATA_W-1:0] c_wr_data;
  line_state_e       c_wr_state;

  // Snoop-side results.
  logic              ev_snp_hit, s_wr_en;
  line_state_e       s_wr_state;

  // Single write port: a snoop update wins the cycle.
  logic              st_wr_en;
  logic [IDX_W-1:0]  st_wr_idx;
  line_state_e       st_wr_state;
  logic [TAG_W-1:0]  st_wr_tag;
  logic [DATA_W-1:0] st_wr_data;

  always_comb begin
    st_wr_en    = s_wr_en || c_wr_en;
    st_wr_idx   = s_wr_en ? snp_idx    : cpu_idx;
    st_wr_state = s_wr_en ? s_wr_state : c_wr_state;
    st_wr_tag   = s_wr_en ? b_tag      : c_wr_tag;
    st_wr_data  = s_wr_en ? b_data     : c_wr_data;
  end

  msi_line_store #(
    .NLINES(NLINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(st_wr_en), .wr_idx(st_wr_idx), .wr_state(st_wr_state),
    .wr_tag(st_wr_tag), .wr_data(st_wr_data),
    .a_idx(cpu_idx), .a_state(a_state), .a_tag(a_tag), .a_data(a_data),
    .b_idx(snp_idx), .b_state(b_state), .b_tag(b_tag), .b_data(b_data)
  );

  msi_cpu_side #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_cpu (
    .req(cpu_req_i), .we(cpu_we_i), .tag(cpu_tag), .wdata(cpu_wdata_i),
    .snoop_busy(snp_valid_i), .gnt(bus_gnt_i),
    .l_state(a_state), .l_tag(a_tag), .l_data(a_data),
    .bus_rdata(bus_rdata_i),
    .ready(cpu_ready_o), .rdata(cpu_rdata_o), .bus_req(bus_req_o),
    .issue(c_issue), .cmd(c_cmd), .bus_tag(c_bus_tag), .bus_data(bus_data_o),
    .wr_en(c_wr_en), .wr_state(c_wr_state), .wr_tag(c_wr_tag),
    .wr_data(c_wr_data), .hit(ev_hit), .wb_issue(ev_wb_issue)
  );

  msi_snoop_side #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .valid(snp_valid_i), .cmd(bus_cmd_e'(snp_cmd_i)), .tag(snp_tag),
    .l_state(b_state), .l_tag(b_tag), .l_data(b_data),
    .hit(ev_snp_hit), .flush(snp_flush_o), .data(snp_data_o),
    .wr_en(s_wr_en), .wr_state(s_wr_state)
  );

  assign bus_valid_o = c_issue;
  assign bus_cmd_o   = c_issue ? c_cmd : BC_NONE;
  assign bus_addr_o  = {c_bus_tag, cpu_idx};

endmodule

// File: rtl/msi_cache_chk.sv
`timescale 1ns/1ps
module msi_cache_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_ready,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              bus_valid,
  input logic [1:0]        bus_cmd,
  input logic              snp_valid,
  input logic [1:0]        snp_cmd,
  input logic [ADDR_W-1:0] snp_addr,
  input logic              snp_flush,
  input logic              ev_hit,
  input logic              ev_wb_issue
);

  AST_VALID_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_gnt); // R10

  AST_SNOOP_BLOCKS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> (!cpu_ready && !bus_valid)); // R9

  AST_STALL_UNTIL_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |-> !cpu_ready); // R8

  AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |-> (!bus_req && cpu_ready)); // R4

  AST_WB_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_cmd == 2'd3) |-> (!cpu_ready && ev_wb_issue)); // R7

  AST_WB_THEN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wb_issue |=> (bus_req || snp_valid)); // R7

  AST_FLUSH_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> (snp_valid && (snp_cmd == 2'd1 || snp_cmd == 2'd2))); // R5

  AST_FLUSH_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |=> !(snp_flush && $stable(snp_addr))); // R6

endmodule

bind msi_snoop_cache msi_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready_o), .bus_req(bus_req_o),
  .bus_gnt(bus_gnt_i), .bus_valid(bus_valid_o), .bus_cmd(bus_cmd_o),
  .snp_valid(snp_valid_i), .snp_cmd(snp_cmd_i), .snp_addr(snp_addr_i),
  .snp_flush(snp_flush_o), .ev_hit(ev_hit), .ev_wb_issue(ev_wb_issue)
);

// File: tb/msi_snoop_cache_tb.sv
`timescale 1ns/1ps
module msi_snoop_cache_tb;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam int WD_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  logic          cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_ready_o;
  logic [DW-1:0] cpu_rdata_o;
  logic          bus_req_o, bus_valid_o;
  logic          bus_gnt = 0;
  logic [1:0]    bus_cmd_o;
  logic [AW-1:0] bus_addr_o;
  logic [DW-1:0] bus_data_o, bus_rdata;
  logic          snp_valid = 0;
  logic [1:0]    snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic          snp_flush_o;
  logic [DW-1:0] snp_data_o;

  logic [DW-1:0] mem [256];
  assign bus_rdata = mem[bus_addr_o];

  msi_snoop_cache #(.NLINES(4), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_ready_o(cpu_ready_o), .cpu_rdata_o(cpu_rdata_o),
    .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt), .bus_valid_o(bus_valid_o),
    .bus_cmd_o(bus_cmd_o), .bus_addr_o(bus_addr_o), .bus_data_o(bus_data_o),
    .bus_rdata_i(bus_rdata),
    .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr),
    .snp_flush_o(snp_flush_o), .snp_data_o(snp_data_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int gdelay = 0;

  function automatic logic [DW-1:0] mem_init(int a);
    return DW'(16'h0100 + a * 3);
  endfunction

  task automatic check(input bit ok, input string r, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", r, act, exp);
    end
  endtask

  // Scoreboard queues.
  logic [DW:0]       cpu_q[$];   // {check_data, rdata}
  string             cpu_r[$];
  logic [DW+AW+2:0]  bus_q[$];   // {check_data, cmd, addr, data}
  string             bus_r[$];

  task automatic exp_bus(input logic [1:0] cmd, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input bit chk, input string r);
    bus_q.push_back({chk, cmd, a, d});
    bus_r.push_back(r);
  endtask

  // Bus model: memory absorbs write-backs.
  always @(posedge clk)
    if (bus_valid_o && bus_cmd_o == 2'd3) mem[bus_addr_o] <= bus_data_o;

  // Arbiter with a programmable grant delay.
  int gcnt = 0;
  always begin
    @(negedge clk);
    #0.5;
    bus_gnt = bus_req_o && (gcnt >= gdelay);
    if (bus_gnt) gcnt = 0;
    else if (bus_req_o) gcnt = gcnt + 1;
    else gcnt = 0;
  end

  // Monitor: pops expected items as the design produces them.
  always begin
    @(negedge clk);
    #1;
    if (rst_n && cpu_req && cpu_ready_o) begin
      if (cpu_q.size() == 0) check(0, "R4 unexpected completion", 1, 0);
      else begin
        logic [DW:0] e;
        string r;
        e = cpu_q.pop_front();
        r = cpu_r.pop_front();
        if (e[DW]) check(cpu_rdata_o == e[DW-1:0], r, cpu_rdata_o, e[DW-1:0]);
      end
    end
    if (rst_n && bus_valid_o) begin
      check(bus_gnt == 1'b1, "R10 valid without grant", bus_gnt, 1);
      if (bus_q.size() == 0) check(0, "R4 unexpected bus transaction", bus_cmd_o, 0);
      else begin
        logic [DW+AW+2:0] e;
        string r;
        e = bus_q.pop_front();
        r = bus_r.pop_front();
        check(bus_cmd_o == e[DW+AW+1:DW+AW], {r, " cmd"}, bus_cmd_o, e[DW+AW+1:DW+AW]);
        check(bus_addr_o == e[DW+AW-1:DW], {r, " addr"}, bus_addr_o, e[DW+AW-1:DW]);
        if (e[DW+AW+2]) check(bus_data_o == e[DW-1:0], {r, " data"}, bus_data_o, e[DW-1:0]);
      end
    end
  end

  task automatic cpu_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input logic [DW-1:0] exp_rd, input string r, output int waited);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    cpu_q.push_back({!we, exp_rd});
    cpu_r.push_back(r);
    #1;
    waited = 0;
    while (!cpu_ready_o) begin
      @(negedge clk);
      #1;
      waited++;
    end
    @(posedge clk);
    #1 cpu_req = 0;
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [AW-1:0] a,
                       input bit exp_flush, input logic [DW-1:0] exp_d, input string r);
    @(negedge clk);
    snp_valid = 1; snp_cmd = cmd; snp_addr = a;
    #1;
    check(snp_flush_o == exp_flush, {r, " flush"}, snp_flush_o, exp_flush);
    if (exp_flush) check(snp_data_o == exp_d, {r, " flush data"}, snp_data_o, exp_d);
    if (snp_flush_o) mem[a] = snp_data_o;
    @(posedge clk);
    #1 snp_valid = 0;
  endtask

  initial begin
    int w;
    for (int i = 0; i < 256; i++) mem[i] = mem_init(i);
    repeat (3) @(negedge clk);
    #1;
    check(bus_req_o == 0, "R1 bus_req in reset", bus_req_o, 0);
    check(cpu_ready_o == 0, "R1 ready in reset", cpu_ready_o, 0);
    rst_n = 1;
    @(negedge clk);
    #1;
    check(snp_flush_o == 0, "R1 flush after reset", snp_flush_o, 0);

    // R1 R2: cold read misses, installs Shared.
    exp_bus(2'd1, 8'h10, '0, 0, "R2 read miss");
    cpu_op(0, 8'h10, '0, mem_init(8'h10), "R2 fill data", w);
    cpu_op(0, 8'h10, '0, mem_init(8'h10), "R4 shared read hit", w);
    check(w == 0, "R4 shared read hit latency", w, 0);

    // R3: write to Shared upgrades with a write miss.
    exp_bus(2'd2, 8'h10, '0, 0, "R3 upgrade write miss");
    cpu_op(1, 8'h10, 16'hAAAA, '0, "R3 upgrade", w);
    cpu_op(0, 8'h10, '0, 16'hAAAA, "R4 modified read hit", w);
    cpu_op(1, 8'h10, 16'hBBBB, '0, "R4 modified write hit", w);
    cpu_op(0, 8'h10, '0, 16'hBBBB, "R4 read after write hit", w);

    // R3: write to Invalid line.
    exp_bus(2'd2, 8'h21, '0, 0, "R3 cold write miss");
    cpu_op(1, 8'h21, 16'h1234, '0, "R3 cold write", w);

    // R7: conflict on dirty line 0.
    exp_bus(2'd3, 8'h10, 16'hBBBB, 1, "R7 write-back");
    exp_bus(2'd1, 8'h30, '0, 0, "R7 miss after write-back");
    cpu_op(0, 8'h30, '0, mem_init(8'h30), "R7 conflict read data", w);
    check(mem[8'h10] == 16'hBBBB, "R7 memory holds victim", mem[8'h10], 16'hBBBB);

    // R6: snooped read miss on Modified.
    snoop(2'd1, 8'h21, 1, 16'h1234, "R6 snoop read");
    cpu_op(0, 8'h21, '0, 16'h1234, "R6 still readable", w);
    exp_bus(2'd2, 8'h21, '0, 0, "R6 write needs miss");
    cpu_op(1, 8'h21, 16'h5555, '0, "R6 rewrite", w);

    // R5: snooped write miss on Modified, then on Shared, then tag mismatch.
    snoop(2'd2, 8'h21, 1, 16'h5555, "R5 snoop write on modified");
    exp_bus(2'd1, 8'h21, '0, 0, "R5 invalidated line misses");
    cpu_op(0, 8'h21, '0, 16'h5555, "R5 refetch", w);
    snoop(2'd2, 8'h34, 0, '0, "R5 tag mismatch");
    cpu_op(0, 8'h30, '0, mem_init(8'h30), "R5 mismatch ignored", w);
    snoop(2'd2, 8'h30, 0, '0, "R5 snoop write on shared");
    exp_bus(2'd1, 8'h30, '0, 0, "R5 shared invalidated");
    cpu_op(0, 8'h30, '0, mem_init(8'h30), "R5 refetch shared", w);

    // R8: delayed grant.
    gdelay = 3;
    exp_bus(2'd1, 8'h42, '0, 0, "R8 delayed miss");
    cpu_op(0, 8'h42, '0, mem_init(8'h42), "R8 delayed data", w);
    check(w == 3, "R8 stall cycles", w, 3);
    gdelay = 0;

    // R7: write conflict on dirty line 2.
    exp_bus(2'd2, 8'h42, '0, 0, "R3 upgrade line 2");
    cpu_op(1, 8'h42, 16'h7777, '0, "R3 upgrade line 2", w);
    exp_bus(2'd3, 8'h42, 16'h7777, 1, "R7 write conflict write-back");
    exp_bus(2'd2, 8'h46, '0, 0, "R7 write conflict miss");
    cpu_op(1, 8'h46, 16'h8888, '0, "R7 write conflict", w);
    check(mem[8'h42] == 16'h7777, "R7 memory after write conflict", mem[8'h42], 16'h7777);

    // R9: snoop and processor hit in the same cycle.
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = 8'h30; cpu_wdata = '0;
    snp_valid = 1; snp_cmd = 2'd1; snp_addr = 8'h21;
    cpu_q.push_back({1'b1, mem_init(8'h30)});
    cpu_r.push_back("R9 served after snoop");
    #1;
    check(cpu_ready_o == 0, "R9 hit held off by snoop", cpu_ready_o, 0);
    check(bus_valid_o == 0, "R9 no bus during snoop", bus_valid_o, 0);
    @(posedge clk);
    #1 snp_valid = 0;
    @(negedge clk);
    #1;
    check(cpu_ready_o == 1, "R9 hit after snoop", cpu_ready_o, 1);
    @(posedge clk);
    #1 cpu_req = 0;

    repeat (3) @(negedge clk);
    check(cpu_q.size() == 0, "R4 pending completions", cpu_q.size(), 0);
    check(bus_q.size() == 0, "R4 pending bus items", bus_q.size(), 0);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(WD_CYCLES * 4);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule